// File: doc/BRIEF.md
# Dataway Block Transfer Sequencer

This block is the read engine of a crate controller on a multi-drop instrumentation dataway. After one start command it picks station addresses by itself. For each station it runs a strobed read cycle, captures the returned word and pushes it into a decoupling FIFO that the host side drains at its own pace. It keeps doing this until the block ends.

Three sequencing modes share the same cycle engine, word counter and FIFO:

- **Request mode** serves only the stations that raise their service request line. The lowest station number goes first, and the pending requests are scanned again after every word.
- **Scan mode** counts upward from a programmed start station. It stops at the first station that answers not ready.
- **List mode** walks a list table loaded by the host. It skips entries marked inactive without addressing them.

A programmable start-to-start spacing keeps each mode below the word rate of the dataway. When a block ends, the block gives a one-cycle done pulse, the final word count and an end code.

Top module: `bxs_block_seq`

## Requirements
- R1: In request mode (mode_i = 0) a station n (1..23) is addressed only while its request line req_i[n-1] is high. With no request pending the block stays busy and drives no strobe.
- R2: In request mode the pending requests are re-evaluated before every cycle, and the lowest-numbered requesting station is served first.
- R3: In scan mode (mode_i = 1) stations start_stn_i, start_stn_i+1, ... are read in that order. The first station that samples dw_rdy_i low ends the block with status_o = 1, and its word is not stored.
- R4: In scan mode, a station number that passes 23 ends the block with status_o = 2. A start station of 0 or above 23 ends the block at once with word_cnt_o = 0 and no strobe.
- R5: In list mode (mode_i = 2) table entries 0 .. list_len_i-1 are used in index order. An entry whose active flag is 0, or whose station lies outside 1..23, is skipped without a strobe. The end of the list gives status_o = 2.
- R6: Each read cycle holds dw_strobe_o high for SETTLE+1 clock cycles with a stable dw_stn_o, and samples dw_data_i and dw_rdy_i in the last of them. A not-ready sample ends the block with status_o = 1 in any mode.
- R7: With word_limit_i nonzero, storing the word_limit_i-th word ends the block with status_o = 3. A limit of 0 means no limit.
- R8: The spacing between successive strobe rises is max(pace_i, SETTLE+2) cycles while the FIFO has room.
- R9: Stored words leave the FIFO in capture order. While the FIFO is full no new cycle starts, so no word is lost.
- R10: A block ends with done_o high for exactly one cycle. word_cnt_o then holds the number of stored words, and status_o holds its end code until the next start.
- R11: List table writes take effect only while busy_o is low. A write made while busy is ignored.
- R12: After reset: busy_o = 0, done_o = 0, dw_strobe_o = 0, fifo_empty_o = 1, word_cnt_o = 0, status_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a block (taken while idle) |
| mode_i | input | 2 | 0 request, 1 scan, 2 list |
| start_stn_i | input | 5 | First station in scan mode |
| word_limit_i | input | 16 | Word limit, 0 = none |
| pace_i | input | 16 | Minimum cycles from strobe rise to strobe rise |
| list_len_i | input | 6 | Number of list entries used |
| lst_we_i | input | 1 | List table write enable |
| lst_addr_i | input | 5 | List table write index |
| lst_stn_i | input | 5 | Station for the written entry |
| lst_act_i | input | 1 | Active flag for the written entry |
| req_i | input | 23 | Service requests, bit n-1 for station n |
| dw_stn_o | output | 5 | Addressed station (0 outside a cycle) |
| dw_strobe_o | output | 1 | Read strobe |
| dw_data_i | input | 16 | Data returned by the station |
| dw_rdy_i | input | 1 | Ready response of the station |
| fifo_rd_i | input | 1 | Pop the head word |
| fifo_data_o | output | 16 | Head word of the FIFO |
| fifo_empty_o | output | 1 | FIFO holds no word |
| busy_o | output | 1 | A block is running |
| done_o | output | 1 | One-cycle end pulse |
| word_cnt_o | output | 16 | Words stored in the current or last block |
| status_o | output | 2 | 0 none, 1 not ready, 2 sequence exhausted, 3 limit |

## Verification
The hardest situation to reach is the full-FIFO stall in the middle of a block. The host side has to stop draining while the sequencer still has stations to read, and the check needs the FIFO to be small enough to fill quickly. The bench builds the block with a four-word FIFO and holds the drain off during a full scan. It then confirms that the sequencer stays busy with no strobe and a word count of four, and it writes the list table during that window. After the drain is released, all 23 words must arrive in order, and a later list run must show the old table entry.

// File: rtl/bxs_pkg.sv
package bxs_pkg;
  typedef enum logic [1:0] {
    MODE_REQ  = 2'd0,
    MODE_SCAN = 2'd1,
    MODE_LIST = 2'd2
  } xfer_mode_e;

  typedef enum logic [1:0] {
    END_NONE      = 2'd0,
    END_NOT_READY = 2'd1,
    END_EXHAUSTED = 2'd2,
    END_LIMIT     = 2'd3
  } end_code_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_PICK = 2'd1,
    S_STRB = 2'd2
  } seq_state_e;
endpackage

// File: rtl/bxs_list_mem.sv
module bxs_list_mem #(
  parameter int DEPTH = 32,
  parameter int STN_W = 5,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [STN_W-1:0] wstn_i,
  input  logic             wact_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [STN_W-1:0] rstn_o,
  output logic             ract_o
);
  logic [STN_W-1:0] stn_q [DEPTH];
  logic [DEPTH-1:0] act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
      for (int i = 0; i < DEPTH; i++) stn_q[i] <= '0;
    end else if (we_i) begin
      stn_q[waddr_i] <= wstn_i;
      act_q[waddr_i] <= wact_i;
    end
  end

  assign rstn_o = stn_q[raddr_i];
  assign ract_o = act_q[raddr_i];
endmodule

// File: rtl/bxs_req_prio.sv
module bxs_req_prio #(
  parameter int N     = 23,
  parameter int STN_W = 5
) (
  input  logic [N-1:0]     req_i,
  output logic             valid_o,
  output logic [STN_W-1:0] stn_o
);
  // descending loop: the lowest station assigned last wins
  always_comb begin
    valid_o = 1'b0;
    stn_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        valid_o = 1'b1;
        stn_o   = STN_W'(i + 1);
      end
    end
  end
endmodule

// File: rtl/bxs_fifo.sv
module bxs_fifo #(
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] data_o,
  output logic              empty_o,
  output logic              full_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [AW:0]       fill;
  logic              do_pop;

  assign empty_o = (fill == '0);
  assign full_o  = (fill == (AW+1)'(DEPTH));
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rd_ptr];

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push_i) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
      if (do_pop) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
      fill <= fill + (AW+1)'(push_i) - (AW+1)'(do_pop);
    end
  end

  assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  assert_no_underflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |=> $stable(rd_ptr));
endmodule

// File: rtl/bxs_block_seq.sv
module bxs_block_seq
  import bxs_pkg::*;
#(
  parameter int STN_W      = 5,
  parameter int STN_MAX    = 23,
  parameter int DATA_W     = 16,
  parameter int CNT_W      = 16,
  parameter int PACE_W     = 16,
  parameter int FIFO_DEPTH = 1024,
  parameter int LIST_DEPTH = 32,
  parameter int SETTLE     = 2,
  localparam int LIST_AW = $clog2(LIST_DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [1:0]         mode_i,
  input  logic [STN_W-1:0]   start_stn_i,
  input  logic [CNT_W-1:0]   word_limit_i,
  input  logic [PACE_W-1:0]  pace_i,
  input  logic [LIST_AW:0]   list_len_i,
  input  logic               lst_we_i,
  input  logic [LIST_AW-1:0] lst_addr_i,
  input  logic [STN_W-1:0]   lst_stn_i,
  input  logic               lst_act_i,
  input  logic [STN_MAX-1:0] req_i,
  output logic [STN_W-1:0]   dw_stn_o,
  output logic               dw_strobe_o,
  input  logic [DATA_W-1:0]  dw_data_i,
  input  logic               dw_rdy_i,
  input  logic               fifo_rd_i,
  output logic [DATA_W-1:0]  fifo_data_o,
  output logic               fifo_empty_o,
  output logic               busy_o,
  output logic               done_o,
  output logic [CNT_W-1:0]   word_cnt_o,
  output logic [1:0]         status_o
);
  localparam int SET_W = (SETTLE < 1) ? 1 : $clog2(SETTLE + 1);
  localparam logic [STN_W-1:0] STN_LAST = STN_W'(STN_MAX);

  seq_state_e           state;
  xfer_mode_e           mode_q;
  end_code_e            status_q;
  logic [STN_W-1:0]     cur_stn;
  logic [LIST_AW:0]     lst_idx, len_q;
  logic [SET_W-1:0]     settle_cnt;
  logic [PACE_W-1:0]    pace_cnt, pace_q;
  logic [CNT_W-1:0]     word_cnt, limit_q, wc_nxt;
  logic                 done_q;

  logic [STN_W-1:0]     ent_stn, req_stn, nxt_stn;
  logic                 ent_act, req_valid, fifo_full;
  logic                 launch, skip, finish, last_beat, fifo_push;
  end_code_e            fin_code;

  bxs_list_mem #(.DEPTH(LIST_DEPTH), .STN_W(STN_W)) u_list (
    .clk_i, .rst_ni,
    .we_i(lst_we_i && (state == S_IDLE)),
    .waddr_i(lst_addr_i), .wstn_i(lst_stn_i), .wact_i(lst_act_i),
    .raddr_i(lst_idx[LIST_AW-1:0]), .rstn_o(ent_stn), .ract_o(ent_act)
  );

  bxs_req_prio #(.N(STN_MAX), .STN_W(STN_W)) u_prio (
    .req_i, .valid_o(req_valid), .stn_o(req_stn)
  );

  assign last_beat = (state == S_STRB) && (settle_cnt == SET_W'(SETTLE));
  assign fifo_push = last_beat && dw_rdy_i;
  assign wc_nxt    = word_cnt + CNT_W'(1);

  bxs_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(DATA_W)) u_fifo (
    .clk_i, .rst_ni, .push_i(fifo_push), .data_i(dw_data_i),
    .pop_i(fifo_rd_i), .data_o(fifo_data_o), .empty_o(fifo_empty_o), .full_o(fifo_full)
  );

  // next-station choice while in S_PICK
  always_comb begin
    launch   = 1'b0;
    skip     = 1'b0;
    finish   = 1'b0;
    fin_code = END_EXHAUSTED;
    nxt_stn  = cur_stn;
    if (state == S_PICK) begin
      unique case (mode_q)
        MODE_REQ: begin
          nxt_stn = req_stn;
          launch  = req_valid && !fifo_full && (pace_cnt <= PACE_W'(1));
        end
        MODE_LIST: begin
          nxt_stn = ent_stn;
          if (lst_idx >= len_q) finish = 1'b1;
          else if (!ent_act || ent_stn == '0 || ent_stn > STN_LAST) skip = 1'b1;
          else launch = !fifo_full && (pace_cnt <= PACE_W'(1));
        end
        default: begin
          if (cur_stn == '0 || cur_stn > STN_LAST) finish = 1'b1;
          else launch = !fifo_full && (pace_cnt <= PACE_W'(1));
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state      <= S_IDLE;
      mode_q     <= MODE_REQ;
      status_q   <= END_NONE;
      cur_stn    <= '0;
      lst_idx    <= '0;
      len_q      <= '0;
      settle_cnt <= '0;
      pace_cnt   <= '0;
      pace_q     <= '0;
      word_cnt   <= '0;
      limit_q    <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (pace_cnt != '0) pace_cnt <= pace_cnt - PACE_W'(1);
      unique case (state)
        S_IDLE: if (start_i) begin
          mode_q   <= (mode_i == 2'd3) ? MODE_SCAN : xfer_mode_e'(mode_i);
          limit_q  <= word_limit_i;
          pace_q   <= pace_i;
          len_q    <= list_len_i;
          cur_stn  <= start_stn_i;
          lst_idx  <= '0;
          word_cnt <= '0;
          status_q <= END_NONE;
          pace_cnt <= '0;
          state    <= S_PICK;
        end
        S_PICK: begin
          if (finish) begin
            state    <= S_IDLE;
            done_q   <= 1'b1;
            status_q <= fin_code;
          end else if (skip) begin
            lst_idx <= lst_idx + (LIST_AW+1)'(1);
          end else if (launch) begin
            cur_stn    <= nxt_stn;
            settle_cnt <= '0;
            pace_cnt   <= pace_q;
            state      <= S_STRB;
          end
        end
        S_STRB: begin
          if (!last_beat) begin
            settle_cnt <= settle_cnt + SET_W'(1);
          end else if (!dw_rdy_i) begin
            state    <= S_IDLE;
            done_q   <= 1'b1;
            status_q <= END_NOT_READY;
          end else begin
            word_cnt <= wc_nxt;
            if (limit_q != '0 && wc_nxt == limit_q) begin
              state    <= S_IDLE;
              done_q   <= 1'b1;
              status_q <= END_LIMIT;
            end else begin
              state <= S_PICK;
              if (mode_q == MODE_SCAN) cur_stn <= cur_stn + STN_W'(1);
              if (mode_q == MODE_LIST) lst_idx <= lst_idx + (LIST_AW+1)'(1);
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign dw_strobe_o = (state == S_STRB);
  assign dw_stn_o    = (state == S_STRB) ? cur_stn : '0;
  assign busy_o      = (state != S_IDLE);
  assign done_o      = done_q;
  assign word_cnt_o  = word_cnt;
  assign status_o    = status_q;

  // checker: cycles since the last strobe rise
  logic              strb_d;
  logic [PACE_W:0]   gap_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strb_d  <= 1'b0;
      gap_cnt <= '1;
    end else begin
      strb_d <= dw_strobe_o;
      if (state == S_IDLE && start_i) gap_cnt <= '1;
      else if (dw_strobe_o && !strb_d) gap_cnt <= (PACE_W+1)'(1);
      else if (gap_cnt != '1) gap_cnt <= gap_cnt + (PACE_W+1)'(1);
    end
  end

  assert_pace_spacing_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dw_strobe_o && !strb_d) |-> (gap_cnt >= {1'b0, pace_q}));
  assert_req_served_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch && mode_q == MODE_REQ) |-> req_i[nxt_stn - STN_W'(1)]);
  assert_stn_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dw_strobe_o && strb_d) |-> $stable(dw_stn_o));
  assert_stn_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dw_strobe_o |-> (dw_stn_o != '0 && dw_stn_o <= STN_LAST));
  assert_done_code_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (status_o != 2'd0 && !busy_o));
  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: tb/bxs_block_seq_tb_top.sv
`timescale 1ns/1ps
module bxs_block_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = '0;
  logic [4:0]  start_stn = '0;
  logic [15:0] limit = '0;
  logic [15:0] pace = '0;
  logic [5:0]  list_len = '0;
  logic        lst_we = 1'b0;
  logic [4:0]  lst_addr = '0;
  logic [4:0]  lst_stn = '0;
  logic        lst_act = 1'b0;
  logic [22:0] lam_q = '0;
  logic [4:0]  dw_stn;
  logic        dw_strobe;
  logic [15:0] dw_data;
  logic        dw_rdy;
  logic        fifo_rd = 1'b0;
  logic [15:0] fifo_data;
  logic        fifo_empty, busy, done;
  logic [15:0] word_cnt;
  logic [1:0]  status;

  logic [31:0] rdy_map = '1;
  logic [31:0] seen = '0;
  logic        drain = 1'b1;
  logic        lam_clr = 1'b0;
  int          checks = 0, errors = 0, cyc = 0;
  int          last_rise = 0, interval = 0, hi_len = 0, width = 0;
  logic        strb_prev = 1'b0;
  logic [15:0] exp_q [$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  assign dw_rdy  = rdy_map[dw_stn];
  assign dw_data = {8'hA5, 3'b000, dw_stn};

  bxs_block_seq #(.FIFO_DEPTH(4)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .start_stn_i(start_stn), .word_limit_i(limit), .pace_i(pace),
    .list_len_i(list_len), .lst_we_i(lst_we), .lst_addr_i(lst_addr),
    .lst_stn_i(lst_stn), .lst_act_i(lst_act), .req_i(lam_q),
    .dw_stn_o(dw_stn), .dw_strobe_o(dw_strobe), .dw_data_i(dw_data),
    .dw_rdy_i(dw_rdy), .fifo_rd_i(fifo_rd), .fifo_data_o(fifo_data),
    .fifo_empty_o(fifo_empty), .busy_o(busy), .done_o(done),
    .word_cnt_o(word_cnt), .status_o(status)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: strobe timing, station tracking, scoreboard pop
  always @(negedge clk) begin
    if (dw_strobe) begin
      seen[dw_stn] = 1'b1;
      hi_len++;
      if (lam_clr && dw_stn != 0) lam_q[dw_stn - 1] = 1'b0;
      if (!strb_prev) begin
        interval  = cyc - last_rise;
        last_rise = cyc;
      end
    end else if (strb_prev) begin
      width  = hi_len;
      hi_len = 0;
    end
    strb_prev = dw_strobe;
    if (drain && !fifo_empty) begin
      if (exp_q.size() == 0) chk(0, "R9 unexpected word", fifo_data, 0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk(fifo_data == e, "R9 word order", fifo_data, e);
      end
      fifo_rd = 1'b1;
    end else fifo_rd = 1'b0;
  end

  task automatic expect_stn(input int s);
    exp_q.push_back({8'hA5, 3'b000, 5'(s)});
  endtask

  task automatic go(input int m, input int s, input int lim, input int p, input int len);
    @(negedge clk);
    mode = 2'(m); start_stn = 5'(s); limit = 16'(lim); pace = 16'(p); list_len = 6'(len);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req, input int exp_st, input int exp_cnt);
    bit got = 0;
    for (int i = 0; i < 5000; i++) begin
      if (done) begin got = 1; break; end
      @(negedge clk);
    end
    chk(got, {req, " done seen"}, got, 1);
    chk(status == 2'(exp_st), {req, " status"}, status, exp_st);
    chk(word_cnt == 16'(exp_cnt), {req, " count"}, word_cnt, exp_cnt);
    @(negedge clk);
    chk(!done && !busy, "R10 done one cycle", done, 0);
  endtask

  task automatic wait_drain(input string req);
    for (int i = 0; i < 300; i++) begin
      if (exp_q.size() == 0 && fifo_empty) break;
      @(negedge clk);
    end
    chk(exp_q.size() == 0, {req, " all words out"}, exp_q.size(), 0);
  endtask

  task automatic load(input int a, input int s, input bit act);
    @(negedge clk);
    lst_we = 1'b1; lst_addr = 5'(a); lst_stn = 5'(s); lst_act = act;
    @(negedge clk);
    lst_we = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(!busy && !done && !dw_strobe, "R12 idle outputs", busy, 0);
    chk(fifo_empty && word_cnt == 0 && status == 0, "R12 empty/count/status", word_cnt, 0);

    // R3 scan stops at first not-ready (station 10), R6 strobe width
    rdy_map = '1; rdy_map[10] = 1'b0;
    for (int s = 5; s <= 9; s++) expect_stn(s);
    go(1, 5, 0, 0, 0);
    wait_done("R3", 1, 5);
    chk(width == 3, "R6 strobe width", width, 3);
    repeat (4) @(negedge clk);
    chk(status == 1, "R10 status held", status, 1);
    wait_drain("R3");

    // R4 scan passes station 23, and invalid start station
    rdy_map = '1;
    for (int s = 20; s <= 23; s++) expect_stn(s);
    go(1, 20, 0, 0, 0);
    wait_done("R4", 2, 4);
    wait_drain("R4");
    seen = '0;
    go(1, 0, 0, 0, 0);
    wait_done("R4 start 0", 2, 0);
    chk(seen == 0, "R4 no strobe", seen, 0);

    // R5 list with inactive entry 1 (station 7), len 4 leaves entry 4 unused
    load(0, 3, 1); load(1, 7, 0); load(2, 11, 1); load(3, 2, 1); load(4, 9, 1);
    seen = '0;
    expect_stn(3); expect_stn(11); expect_stn(2);
    go(2, 0, 0, 0, 4);
    wait_done("R5", 2, 3);
    chk(!seen[7] && !seen[9], "R5 skipped stations", seen, 0);
    wait_drain("R5");

    // R1/R2 request mode: idle wait, then lowest first with rescan
    seen = '0; lam_clr = 1'b1;
    go(0, 0, 3, 0, 0);
    repeat (20) @(negedge clk);
    chk(busy && seen == 0, "R1 waits without strobe", seen, 0);
    lam_q[14] = 1'b1; lam_q[3] = 1'b1; lam_q[8] = 1'b1;
    expect_stn(4); expect_stn(9); expect_stn(15);
    wait_done("R7 limit req", 3, 3);
    chk(seen == 32'h0000_8210, "R1 only requesters addressed", seen, 32'h8210);
    wait_drain("R2");
    lam_clr = 1'b0;

    // R7 limit in scan mode
    expect_stn(1); expect_stn(2);
    go(1, 1, 2, 0, 0);
    wait_done("R7", 3, 2);
    wait_drain("R7");

    // R8 pacing
    for (int s = 1; s <= 3; s++) expect_stn(s);
    go(1, 1, 3, 10, 0);
    wait_done("R8 pace 10", 3, 3);
    chk(interval == 10, "R8 spacing pace 10", interval, 10);
    wait_drain("R8");
    for (int s = 1; s <= 3; s++) expect_stn(s);
    go(1, 1, 3, 0, 0);
    wait_done("R8 pace 0", 3, 3);
    chk(interval == 4, "R8 spacing minimum", interval, 4);
    wait_drain("R8b");

    // R9 full-FIFO stall, R11 write while busy
    drain = 1'b0;
    for (int s = 1; s <= 23; s++) expect_stn(s);
    go(1, 1, 0, 0, 0);
    repeat (60) @(negedge clk);
    chk(busy && !dw_strobe && word_cnt == 4, "R9 stalled at full", word_cnt, 4);
    load(0, 9, 1);
    drain = 1'b1;
    wait_done("R9", 2, 23);
    wait_drain("R9");

    seen = '0;
    expect_stn(3);
    go(2, 0, 0, 0, 1);
    wait_done("R11", 2, 1);
    chk(seen[3] && !seen[9], "R11 busy write ignored", seen, 8);
    wait_drain("R11");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule